// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block sits between sixteen parallel lanes and a word-addressed memory port. A group request carries one address per lane, an active-lane mask, a read/write flag and, for writes, one 32-bit word per lane. Addresses count 32-bit words. The block checks whether the active lanes form one aligned run of sixteen words, with each lane at its own offset inside that run.

When they do, the block sends a single 16-word transaction to memory. Otherwise it sends one single-word transaction for each active lane, from the lowest lane upward, and waits for each response before it sends the next. Read results are steered back into the lane slots of a result vector. A one-cycle completion strobe marks the end of the group.

The memory side has a valid/ready request channel and a response strobe. The block keeps only one transaction outstanding at a time. A new group can be accepted in the same cycle that the previous group signals completion.

Top module: `halfgroup_coalescer`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req_valid` is 0, `done` is 0 and `rdata` is all zeros.
- R2: If every active lane N has address bits [3:0] equal to N, and all active lanes share the same address bits above bit 3, the group produces exactly one memory request. That request has `mem_req_len` = 16, an address equal to the shared upper bits with bits [3:0] cleared, and `mem_req_strb` equal to the lane mask.
- R3: For a merged read, each active lane N receives bits [32N+31:32N] of the response word vector in `rdata` slot N.
- R4: Inactive lanes never prevent a merge, whatever their addresses. Their strobe bit is 0 and their `rdata` slot reads zero.
- R5: A group that fails the R2 test issues one request per active lane, in ascending lane order. Each request has `mem_req_len` = 1, the lane's own address, and `mem_req_strb` = 1 (bit 0 only). A contiguous run with a misaligned start, and lanes with duplicate addresses, both fall into this case.
- R6: For a single-word read, the lane's `rdata` slot receives response bits [31:0].
- R7: A merged write carries every lane's write word in its own slot of `mem_req_wdata`. A single-word write carries the lane's word in bits [31:0] with all other bits zero. After a write group, `rdata` is all zeros.
- R8: A group with an all-zero mask sends no memory request, and `done` rises in the cycle after acceptance.
- R9: A new memory request follows only the response to the previous one. `done` is high for the cycle after the final response is taken, so with a ready memory a group of k transactions completes 3k cycles after acceptance.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, length, strobes and write data stay unchanged.
- R11: `req_ready` is high when the block is idle and during the `done` cycle. A group accepted in the `done` cycle is processed normally, and `rdata` still shows the previous group's results during that `done` cycle.
- R12: `req_valid` is ignored while a group is in progress. It starts no extra transaction and does not change the current group's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Group request present |
| req_ready | output | 1 | Block can accept a group |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_mask | input | LANES | Active-lane mask |
| req_addr | input | LANES*AW | Per-lane word addresses, lane N at bits [AW*N +: AW] |
| req_wdata | input | LANES*DW | Per-lane write words |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | AW | Start word address |
| mem_req_len | output | LW+1 | Words in transaction (16 or 1) |
| mem_req_strb | output | LANES | Word enables |
| mem_req_wdata | output | LANES*DW | Write words |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | LANES*DW | Response words |
| done | output | 1 | One-cycle group completion strobe |
| rdata | output | LANES*DW | Per-lane read results |

## Verification
Two events can fall in the same cycle: the completion of one group and the acceptance of the next. The bench waits until it sees `done`, then presents a second group in that same cycle. At that point it checks that `rdata` still holds the first group's lane values. After the second group completes, it checks the second group's transactions and results in full. A related case raises `req_valid` with unrelated addresses while a stalled group is in flight, and judges from the transaction log and the results that the extra request was not taken.

// File: rtl/halfgroup_coalescer_pkg.sv
`timescale 1ns/1ps
package halfgroup_coalescer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/hgc_pattern.sv
`timescale 1ns/1ps
// Decides whether the active lanes form one aligned contiguous run.
module hgc_pattern #(
  parameter int LANES = 16,
  parameter int AW    = 29
) (
  input  logic [LANES*AW-1:0]        addr,
  input  logic [LANES-1:0]           mask,
  output logic                       mergeable,
  output logic [AW-$clog2(LANES)-1:0] base_hi
);
  localparam int LW = $clog2(LANES);
  localparam int HW = AW - LW;

  logic [HW-1:0] ref_hi;
  logic          all_ok;

  // upper bits of the lowest active lane serve as reference
  always_comb begin
    ref_hi = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (mask[i]) ref_hi = addr[i*AW+LW +: HW];
    end
  end

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) begin
        if (addr[i*AW +: LW] != LW'(i))      all_ok = 1'b0;
        if (addr[i*AW+LW +: HW] != ref_hi)   all_ok = 1'b0;
      end
    end
  end

  assign mergeable = all_ok;
  assign base_hi   = ref_hi;
endmodule

// File: rtl/hgc_sequencer.sv
`timescale 1ns/1ps
// Transaction sequencer: one burst or one request per active lane.
module hgc_sequencer
  import halfgroup_coalescer_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LANES-1:0]          start_mask,
  input  logic                      start_merge,
  input  logic                      mem_req_ready,
  input  logic                      mem_rsp_valid,
  output logic                      accept_ok,
  output logic                      issue_valid,
  output logic                      issue_burst,
  output logic [$clog2(LANES)-1:0]  issue_lane,
  output logic                      rsp_take,
  output logic                      group_done
);
  localparam int LW = $clog2(LANES);

  seq_state_e       state_q, state_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [LW-1:0]    lane_q, lane_d;
  logic             burst_q, burst_d;
  logic [LW-1:0]    last_q, last_d;
  logic             have_last_q, have_last_d;
  logic [LANES-1:0] pend_left;

  function automatic logic [LW-1:0] lowest_set(input logic [LANES-1:0] v);
    lowest_set = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) lowest_set = LW'(i);
    end
  endfunction

  assign accept_ok   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign issue_valid = (state_q == ST_ISSUE);
  assign issue_burst = burst_q;
  assign issue_lane  = lane_q;
  assign rsp_take    = (state_q == ST_WAIT) && mem_rsp_valid;
  assign group_done  = (state_q == ST_DONE);

  always_comb begin
    pend_left = pend_q;
    pend_left[lane_q] = 1'b0;
  end

  always_comb begin
    state_d     = state_q;
    pend_d      = pend_q;
    lane_d      = lane_q;
    burst_d     = burst_q;
    last_d      = last_q;
    have_last_d = have_last_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          pend_d      = start_mask;
          burst_d     = start_merge;
          lane_d      = lowest_set(start_mask);
          have_last_d = 1'b0;
          state_d     = (start_mask == '0) ? ST_DONE : ST_ISSUE;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) begin
          state_d     = ST_WAIT;
          last_d      = lane_q;
          have_last_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (burst_q || (pend_left == '0)) begin
            pend_d  = '0;
            state_d = ST_DONE;
          end else begin
            pend_d  = pend_left;
            lane_d  = lowest_set(pend_left);
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      lane_q      <= '0;
      burst_q     <= 1'b0;
      last_q      <= '0;
      have_last_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      lane_q      <= lane_d;
      burst_q     <= burst_d;
      last_q      <= last_d;
      have_last_q <= have_last_d;
    end
  end

  AST_LANE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_burst && have_last_q |-> issue_lane > last_q); // R5

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid || rsp_take) |-> !accept_ok); // R12
endmodule

// File: rtl/hgc_steer.sv
`timescale 1ns/1ps
// Steers response words into the per-lane result slots.
module hgc_steer #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      cap,
  input  logic                      cap_burst,
  input  logic [$clog2(LANES)-1:0]  cap_lane,
  input  logic [LANES-1:0]          mask,
  input  logic [LANES*DW-1:0]       rsp_data,
  output logic [LANES*DW-1:0]       rdata
);
  localparam int LW = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          hit;
    logic [DW-1:0] src;
    logic [DW-1:0] slot_q, slot_d;

    assign hit = cap && (cap_burst ? mask[g] : (cap_lane == LW'(g)));
    assign src = cap_burst ? rsp_data[g*DW +: DW] : rsp_data[DW-1:0];

    always_comb begin
      slot_d = slot_q;
      if (clear)    slot_d = '0;
      else if (hit) slot_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign rdata[g*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/halfgroup_coalescer.sv
`timescale 1ns/1ps
module halfgroup_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 29,
  parameter int DW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [LANES-1:0]              req_mask,
  input  logic [LANES*AW-1:0]           req_addr,
  input  logic [LANES*DW-1:0]           req_wdata,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_write,
  output logic [AW-1:0]                 mem_req_addr,
  output logic [$clog2(LANES):0]        mem_req_len,
  output logic [LANES-1:0]              mem_req_strb,
  output logic [LANES*DW-1:0]           mem_req_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [LANES*DW-1:0]           mem_rsp_data,
  output logic                          done,
  output logic [LANES*DW-1:0]           rdata
);
  localparam int LW = $clog2(LANES);
  localparam int HW = AW - LW;

  logic                 start;
  logic                 merge_now;
  logic [HW-1:0]        base_now;
  logic                 accept_ok;
  logic                 issue_valid, issue_burst, rsp_take;
  logic [LW-1:0]        issue_lane;

  // group context, loaded on acceptance
  logic [LANES*AW-1:0]  addr_q;
  logic [LANES*DW-1:0]  wdata_q;
  logic [LANES-1:0]     mask_q;
  logic                 write_q;
  logic [HW-1:0]        base_q;

  assign start     = req_valid && accept_ok;
  assign req_ready = accept_ok;

  hgc_pattern #(.LANES(LANES), .AW(AW)) u_pattern (
    .addr      (req_addr),
    .mask      (req_mask),
    .mergeable (merge_now),
    .base_hi   (base_now)
  );

  hgc_sequencer #(.LANES(LANES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_mask    (req_mask),
    .start_merge   (merge_now),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .accept_ok     (accept_ok),
    .issue_valid   (issue_valid),
    .issue_burst   (issue_burst),
    .issue_lane    (issue_lane),
    .rsp_take      (rsp_take),
    .group_done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      write_q <= 1'b0;
      base_q  <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      write_q <= req_write;
      base_q  <= base_now;
    end
  end

  always_comb begin
    mem_req_valid = issue_valid;
    mem_req_write = write_q;
    if (issue_burst) begin
      mem_req_addr  = {base_q, {LW{1'b0}}};
      mem_req_len   = (LW+1)'(LANES);
      mem_req_strb  = mask_q;
      mem_req_wdata = wdata_q;
    end else begin
      mem_req_addr  = addr_q[issue_lane*AW +: AW];
      mem_req_len   = (LW+1)'(1);
      mem_req_strb  = '0;
      mem_req_strb[0] = 1'b1;
      mem_req_wdata = '0;
      mem_req_wdata[DW-1:0] = wdata_q[issue_lane*DW +: DW];
    end
  end

  hgc_steer #(.LANES(LANES), .DW(DW)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .cap       (rsp_take && !write_q),
    .cap_burst (issue_burst),
    .cap_lane  (issue_lane),
    .mask      (mask_q),
    .rsp_data  (mem_rsp_data),
    .rdata     (rdata)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_len) && $stable(mem_req_strb) && $stable(mem_req_wdata)); // R10

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !issue_burst |-> mask_q[issue_lane]); // R5

  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_req_len != (LW+1)'(1)) |-> mem_req_addr[LW-1:0] == '0); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid && req_ready); // R11
endmodule

// File: tb/halfgroup_coalescer_bench.sv
`timescale 1ns/1ps
module halfgroup_coalescer_bench;
  localparam int LANES = 16;
  localparam int AW    = 29;
  localparam int DW    = 32;
  localparam int LW    = 4;

  logic                 clk;
  logic                 rst_n;
  logic                 req_valid;
  logic                 req_ready;
  logic                 req_write;
  logic [LANES-1:0]     req_mask;
  logic [LANES*AW-1:0]  req_addr;
  logic [LANES*DW-1:0]  req_wdata;
  logic                 mem_req_valid;
  logic                 mem_req_ready;
  logic                 mem_req_write;
  logic [AW-1:0]        mem_req_addr;
  logic [LW:0]          mem_req_len;
  logic [LANES-1:0]     mem_req_strb;
  logic [LANES*DW-1:0]  mem_req_wdata;
  logic                 mem_rsp_valid;
  logic [LANES*DW-1:0]  mem_rsp_data;
  logic                 done;
  logic [LANES*DW-1:0]  rdata;

  int n_cmp = 0;
  int n_bad = 0;

  halfgroup_coalescer #(.LANES(LANES), .AW(AW), .DW(DW)) u_halfgroup_coalescer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_len(mem_req_len), .mem_req_strb(mem_req_strb),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model and transaction log
  int                  stall_cfg = 0;
  int                  stall_left;
  int                  hold_cnt;
  int                  log_n;
  logic [AW-1:0]       log_addr  [32];
  logic [LW:0]         log_len   [32];
  logic [LANES-1:0]    log_strb  [32];
  logic                log_write [32];
  logic [LANES*DW-1:0] log_wdata [32];
  logic                pend;
  logic [LANES*DW-1:0] pend_data;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  assign mem_req_ready = (stall_left == 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      log_n <= 0; pend <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      stall_left <= 0; hold_cnt <= 0; pend_data <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pend_data;
        pend          <= 1'b0;
      end
      if (req_valid && req_ready) begin
        log_n <= 0; hold_cnt <= 0; stall_left <= stall_cfg;
      end else if (mem_req_valid && mem_req_ready) begin
        if (log_n < 32) begin
          log_addr[log_n]  <= mem_req_addr;
          log_len[log_n]   <= mem_req_len;
          log_strb[log_n]  <= mem_req_strb;
          log_write[log_n] <= mem_req_write;
          log_wdata[log_n] <= mem_req_wdata;
        end
        log_n      <= log_n + 1;
        pend       <= 1'b1;
        stall_left <= stall_cfg;
        for (int i = 0; i < LANES; i++) begin
          if (mem_req_len == 5'd16) pend_data[i*DW +: DW] <= mem_word(mem_req_addr + AW'(i));
          else if (i == 0)          pend_data[DW-1:0]     <= mem_word(mem_req_addr);
          else                      pend_data[i*DW +: DW] <= 32'hDEAD_0000 | i;
        end
      end else if (mem_req_valid && stall_left > 0) begin
        stall_left <= stall_left - 1;
        hold_cnt   <= hold_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [LANES*AW-1:0] mk_stride(input logic [AW-1:0] base, input int stride);
    logic [LANES*AW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*AW +: AW] = base + AW'(i * stride);
    return v;
  endfunction

  function automatic logic [LANES*AW-1:0] junk_inactive(input logic [LANES*AW-1:0] a, input logic [LANES-1:0] m);
    logic [LANES*AW-1:0] v = a;
    for (int i = 0; i < LANES; i++) if (!m[i]) v[i*AW +: AW] = 29'h1ABC_DE0 + AW'(i * 7);
    return v;
  endfunction

  function automatic logic [LANES*DW-1:0] mk_wdata(input logic [DW-1:0] seed);
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = seed + DW'(i * 32'h0101_0111);
    return v;
  endfunction

  // Present one group, optionally poke req_valid mid-flight; returns cycles until done.
  task automatic launch(input logic wr, input logic [LANES*AW-1:0] a, input logic [LANES*DW-1:0] wd,
                        input logic [LANES-1:0] m, input int stall, input bit poke, output int waited);
    stall_cfg = stall;
    req_write = wr; req_addr = a; req_wdata = wd; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      if (poke && waited < 3) begin
        req_valid = 1'b1; req_addr = mk_stride(29'h0777_0000, 1); req_mask = '1; req_write = 1'b0;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    req_valid = 1'b0;
  endtask

  // Compare log and results at the done cycle against the requirements.
  task automatic judge(input string tag, input logic wr, input logic [LANES*AW-1:0] a,
                       input logic [LANES*DW-1:0] wd, input logic [LANES-1:0] m,
                       input int stall, input int waited);
    logic [AW-LW-1:0] ref_hi;
    bit merge;
    int pc, k, exp_wait;
    ref_hi = '0; merge = 1'b1; pc = 0;
    for (int i = LANES - 1; i >= 0; i--) if (m[i]) ref_hi = a[i*AW+LW +: AW-LW];
    for (int i = 0; i < LANES; i++) if (m[i]) begin
      pc++;
      if (a[i*AW +: LW] != LW'(i) || a[i*AW+LW +: AW-LW] != ref_hi) merge = 1'b0;
    end
    chk(tag, "done seen", 64'(done), 64'd1);
    if (pc == 0) begin
      chk("R8", "transactions", 64'(log_n), 64'd0);
      exp_wait = 0;
    end else if (merge) begin
      exp_wait = 3 + stall;
      chk("R2", "transactions", 64'(log_n), 64'd1);
      chk("R2", "burst addr", 64'(log_addr[0]), 64'({ref_hi, 4'h0}));
      chk("R2", "burst len", 64'(log_len[0]), 64'd16);
      chk("R4", "burst strb", 64'(log_strb[0]), 64'(m));
      chk(tag, "write flag", 64'(log_write[0]), 64'(wr));
      if (wr) for (int i = 0; i < LANES; i++)
        chk("R7", $sformatf("burst wdata lane %0d", i), 64'(log_wdata[0][i*DW +: DW]), 64'(wd[i*DW +: DW]));
      for (int i = 0; i < LANES; i++) begin
        logic [DW-1:0] e;
        e = (!wr && m[i]) ? mem_word({ref_hi, 4'h0} + AW'(i)) : '0;
        chk(m[i] ? (wr ? "R7" : "R3") : "R4", $sformatf("rdata lane %0d", i), 64'(rdata[i*DW +: DW]), 64'(e));
      end
    end else begin
      exp_wait = pc * (3 + stall);
      chk("R5", "transactions", 64'(log_n), 64'(pc));
      k = 0;
      for (int i = 0; i < LANES; i++) if (m[i]) begin
        if (k < 32) begin
          chk("R5", $sformatf("single %0d addr", k), 64'(log_addr[k]), 64'(a[i*AW +: AW]));
          chk("R5", $sformatf("single %0d len", k), 64'(log_len[k]), 64'd1);
          chk("R5", $sformatf("single %0d strb", k), 64'(log_strb[k]), 64'd1);
          if (wr) begin
            chk("R7", $sformatf("single %0d word", k), 64'(log_wdata[k][DW-1:0]), 64'(wd[i*DW +: DW]));
            chk("R7", $sformatf("single %0d upper zero", k), 64'(log_wdata[k][LANES*DW-1:DW] == '0), 64'd1);
          end
        end
        k++;
      end
      for (int i = 0; i < LANES; i++) begin
        logic [DW-1:0] e;
        e = (!wr && m[i]) ? mem_word(a[i*AW +: AW]) : '0;
        chk(wr ? "R7" : "R6", $sformatf("rdata lane %0d", i), 64'(rdata[i*DW +: DW]), 64'(e));
      end
    end
    chk("R9", "cycles to done", 64'(waited), 64'(exp_wait));
    chk("R10", "held cycles", 64'(hold_cnt), 64'(stall * log_n));
  endtask

  task automatic run_case(input string tag, input logic wr, input logic [LANES*AW-1:0] a,
                          input logic [LANES*DW-1:0] wd, input logic [LANES-1:0] m,
                          input int stall, input bit poke);
    int w;
    launch(wr, a, wd, m, stall, poke, w);
    judge(tag, wr, a, wd, m, stall, w);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "rdata zero", 64'(rdata == '0), 64'd1);
  endtask

  task automatic t_burst_read();
    run_case("R3", 1'b0, mk_stride(29'h0001_2340, 1), '0, 16'hFFFF, 0, 1'b0);
  endtask

  task automatic t_masked_burst();
    logic [LANES-1:0] m1 = 16'hB6E5;
    logic [LANES-1:0] m2 = 16'hF0F0;
    run_case("R4", 1'b0, junk_inactive(mk_stride(29'h0000_0A00, 1), m1), '0, m1, 0, 1'b0);
    run_case("R4", 1'b0, junk_inactive(mk_stride(29'h0003_0000, 1), m2), '0, m2, 0, 1'b0);
  endtask

  task automatic t_misaligned();
    run_case("R5", 1'b0, mk_stride(29'h0000_1004, 1), '0, 16'hFFFF, 0, 1'b0);
  endtask

  task automatic t_scattered();
    run_case("R6", 1'b0, mk_stride(29'h0000_0100, 37), '0, 16'h8421, 0, 1'b0);
    run_case("R5", 1'b0, mk_stride(29'h0000_0500, 0), '0, 16'h0103, 0, 1'b0);
  endtask

  task automatic t_writes();
    run_case("R7", 1'b1, mk_stride(29'h0000_2000, 1), mk_wdata(32'hA000_0000), 16'hFFFF, 0, 1'b0);
    run_case("R7", 1'b1, mk_stride(29'h0000_3000, 2), mk_wdata(32'h5000_1234), 16'h0FF0, 0, 1'b0);
  endtask

  task automatic t_zero_mask();
    run_case("R8", 1'b0, mk_stride(29'h0000_4000, 1), '0, 16'h0000, 0, 1'b0);
  endtask

  task automatic t_stall();
    run_case("R12", 1'b0, mk_stride(29'h0000_6000, 1), '0, 16'hFFFF, 3, 1'b1);
    run_case("R10", 1'b1, mk_stride(29'h0000_7005, 1), mk_wdata(32'h0BAD_0000), 16'h0003, 2, 1'b1);
  endtask

  task automatic t_back_to_back();
    logic [LANES*AW-1:0] a1 = mk_stride(29'h0000_8000, 1);
    logic [LANES*AW-1:0] a2 = mk_stride(29'h0000_9003, 5);
    int w;
    launch(1'b0, a1, '0, 16'hFFFF, 0, 1'b0, w);
    judge("R11", 1'b0, a1, '0, 16'hFFFF, 0, w);
    chk("R11", "ready in done cycle", 64'(req_ready), 64'd1);
    launch(1'b0, a2, '0, 16'h0007, 0, 1'b0, w);
    judge("R11", 1'b0, a2, '0, 16'h0007, 0, w);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_mask = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_burst_read();
    t_masked_burst();
    t_misaligned();
    t_scattered();
    t_writes();
    t_zero_mask();
    t_stall();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule